// File: doc/BRIEF.md
# Delayed Parity Checker with Error Hold

This block guards a 22-bit address/command word with a single parity bit that the controller sends one clock after the word it covers. Each word is captured together with a flag telling whether any of the two active-low chip selects was asserted. One cycle later the matching parity bit is captured and compared. The result is registered, and one more cycle later it drives an active-low error output. Odd parity is expected: the word's ones plus the parity bit must be an odd count.

A detected error pulls the error output low for exactly two clock cycles. A further error arriving while that window is open restarts the two-cycle window. Words seen while both chip selects were high are never checked. An asynchronous active-low reset makes the error output inactive at once and empties the pipeline. Until a full word-plus-parity pair has been captured after reset release, nothing is compared.

Top module: `pcheck_top`

## Requirements
- R1: While `rst_n` is low, `err_n` is 1, and it goes to 1 as soon as `rst_n` falls, without waiting for a clock edge.
- R2: Reset discards any word or comparison in flight, so an error captured before reset never shows on `err_n` after release.
- R3: The parity bit sampled at rising edge n+1 is paired with the word sampled at rising edge n.
- R4: When a checked word and its paired parity bit hold an even total of ones, `err_n` goes low right after rising edge n+3 and not earlier, where n is the edge that sampled the word.
- R5: A word sampled while both `cs_n` bits are 1 (11) is not checked, whatever its parity.
- R6: A single error holds `err_n` low for exactly two clock cycles, after which it returns to 1.
- R7: An error that reaches the output while `err_n` is already low restarts the two-cycle window, so `err_n` stays low for two cycles counted from that error.
- R8: The parity bit sampled at the first rising edge after reset release is paired with no word and never raises an error.
- R9: When no checked word has an error, `err_n` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 2 | Chip selects, active low; the word is checked if either bit is 0 |
| word_in | input | 22 | Address/command word sampled each edge |
| par_in | input | 1 | Parity bit for the word sampled one edge earlier |
| err_n | output | 1 | Parity error flag, active low, held two cycles |

## Verification
The case of interest is a new error that reaches the output while the hold window of an earlier error is still counting down. It is set up by giving two back-to-back checked words bad parity. The bench's reference model then expects three low cycles instead of four, because the second error restarts the window and does not extend it by a full two cycles. The other overlap is a word with bad parity sampled while both chip selects are high, landing as an earlier window closes. There the output must return high on time.

// File: rtl/pcheck_pkg.sv
package pcheck_pkg;

    localparam int WORD_W_DEF = 22;
    localparam int CS_W_DEF   = 2;
    localparam int HOLD_DEF   = 2;

    // One entry of the comparison pipeline after the word is reduced
    typedef struct packed {
        logic valid;  // a real word was captured since reset release
        logic sel;    // at least one chip select was active for it
        logic wpar;   // XOR of all word bits
    } chk_slot_t;

    localparam chk_slot_t SLOT_IDLE = '{valid: 1'b0, sel: 1'b0, wpar: 1'b0};

    // Odd parity wanted: word ones plus parity bit must be odd
    function automatic logic parity_bad(input logic wpar, input logic pbit);
        return ~(wpar ^ pbit);
    endfunction

endpackage

// File: rtl/pcheck_stage.sv
module pcheck_stage
    import pcheck_pkg::*;
#(
    parameter int WORD_W       = WORD_W_DEF,
    parameter int CS_W         = CS_W_DEF,
    parameter bit REDUCE_EARLY = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] word_in,
    input  logic [CS_W-1:0]   cs_n,
    input  logic              par_in,
    output chk_slot_t         slot_q,
    output logic              par_q
);

    logic cs_hit;
    assign cs_hit = ~&cs_n;

    generate
        if (REDUCE_EARLY) begin : g_early
            // Reduce the word at capture: one bit of storage per stage
            chk_slot_t cap_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cap_q  <= SLOT_IDLE;
                    slot_q <= SLOT_IDLE;
                end else begin
                    cap_q  <= '{valid: 1'b1, sel: cs_hit, wpar: ^word_in};
                    slot_q <= cap_q;
                end
            end
        end else begin : g_late
            // Keep the full word one cycle, reduce on the way out
            logic [WORD_W-1:0] word_q;
            logic              sel_q;
            logic              vld_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    word_q <= '0;
                    sel_q  <= 1'b0;
                    vld_q  <= 1'b0;
                    slot_q <= SLOT_IDLE;
                end else begin
                    word_q <= word_in;
                    sel_q  <= cs_hit;
                    vld_q  <= 1'b1;
                    slot_q <= '{valid: vld_q, sel: sel_q, wpar: ^word_q};
                end
            end
        end
    endgenerate

    // Parity arrives one edge after its word
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) par_q <= 1'b0;
        else        par_q <= par_in;
    end

endmodule

// File: rtl/pcheck_cmp.sv
module pcheck_cmp
    import pcheck_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  chk_slot_t slot,
    input  logic      pbit,
    output logic      err_q
);

    logic bad_now;
    assign bad_now = slot.valid & slot.sel & parity_bad(slot.wpar, pbit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= bad_now;
    end

endmodule

// File: rtl/pcheck_hold.sv
module pcheck_hold #(
    parameter int HOLD_CYC = pcheck_pkg::HOLD_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    output logic err_n
);

    localparam int CNT_W = $clog2(HOLD_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_CYC);

    logic [CNT_W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (hit) begin
            left_q <= CNT_LOAD;           // new error restarts the window
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign err_n = (left_q == '0);

endmodule

// File: rtl/pcheck_top.sv
module pcheck_top
    import pcheck_pkg::*;
#(
    parameter int WORD_W       = WORD_W_DEF,
    parameter int CS_W         = CS_W_DEF,
    parameter int HOLD_CYC     = HOLD_DEF,
    parameter bit REDUCE_EARLY = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CS_W-1:0]   cs_n,
    input  logic [WORD_W-1:0] word_in,
    input  logic              par_in,
    output logic              err_n
);

    chk_slot_t slot_q;
    logic      par_q;
    logic      cmp_err;
    logic      sel_stage2;

    pcheck_stage #(
        .WORD_W      (WORD_W),
        .CS_W        (CS_W),
        .REDUCE_EARLY(REDUCE_EARLY)
    ) u_stage (
        .clk    (clk),
        .rst_n  (rst_n),
        .word_in(word_in),
        .cs_n   (cs_n),
        .par_in (par_in),
        .slot_q (slot_q),
        .par_q  (par_q)
    );

    pcheck_cmp u_cmp (
        .clk  (clk),
        .rst_n(rst_n),
        .slot (slot_q),
        .pbit (par_q),
        .err_q(cmp_err)
    );

    pcheck_hold #(
        .HOLD_CYC(HOLD_CYC)
    ) u_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .hit  (cmp_err),
        .err_n(err_n)
    );

    assign sel_stage2 = slot_q.sel;

endmodule

// File: rtl/pcheck_chk.sv
module pcheck_chk (
    input logic clk,
    input logic rst_n,
    input logic err_n,
    input logic sel2,
    input logic cmp_err
);

    always @(posedge clk) begin
        if (!rst_n) AST_RESET_IDLE: assert (err_n); // R1
    end

    AST_GATED_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !sel2 |=> !cmp_err); // R5

    AST_FLAG_DRIVES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_err |=> !err_n); // R4

    AST_LOW_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_n) |=> !err_n); // R6

    AST_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_err && !err_n) |=> (!err_n ##1 !err_n)); // R7

endmodule

bind pcheck_top pcheck_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .err_n  (err_n),
    .sel2   (sel_stage2),
    .cmp_err(cmp_err)
);

// File: tb/sim_pcheck_top.sv
module sim_pcheck_top;

    typedef struct packed {
        logic [1:0]  cs;
        logic [21:0] w;
        logic        good;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{2'b10, 22'h000001, 1'b1},
        '{2'b01, 22'h3FFFFF, 1'b0},  // error, R3 pairing
        '{2'b00, 22'h155555, 1'b1},
        '{2'b11, 22'h0ABCDE, 1'b0},  // R5: both deselected, ignored
        '{2'b10, 22'h2AAAAA, 1'b0},  // error
        '{2'b01, 22'h123456, 1'b0},  // R7: restarts the window
        '{2'b00, 22'h000000, 1'b1},
        '{2'b11, 22'h3FFFFF, 1'b0},  // R5
        '{2'b11, 22'h000000, 1'b1},
        '{2'b10, 22'h00F0F0, 1'b0},  // R6: lone error, two cycles
        '{2'b00, 22'h000001, 1'b1},
        '{2'b00, 22'h000002, 1'b1},
        '{2'b11, 22'h000003, 1'b0},  // R5 while window closes
        '{2'b01, 22'h3C3C3C, 1'b1},
        '{2'b00, 22'h000000, 1'b0},  // error
        '{2'b10, 22'h000001, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic [1:0]  cs_n = 2'b11;
    logic [21:0] word_in = '0;
    logic        par_in = 1'b0;
    logic        err_n;

    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    pcheck_top u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .word_in(word_in),
        .par_in (par_in),
        .err_n  (err_n)
    );

    function automatic logic pbit(input vec_t v);
        return v.good ? ~(^v.w) : (^v.w);
    endfunction

    function automatic logic evt(input vec_t v);
        return (v.cs != 2'b11) && !v.good;
    endfunction

    task automatic chk(input logic exp, input string tag);
        total++;
        if (err_n !== exp) begin
            bad++;
            $display("FAIL %s err_n=%0b expected %0b at %0t", tag, err_n, exp, $time);
        end
    endtask

    task automatic done();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        done();
    end

    initial begin
        int h;
        #1 rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(1'b1, "R1 reset state");

        // Table walk: word for edge 0, parity at edge 0 pairs with nothing (R8)
        cs_n = TBL[0].cs; word_in = TBL[0].w; par_in = 1'b0;
        rst_n = 1'b1;
        h = 0;
        for (int e = 0; e < NV + 4; e++) begin
            @(negedge clk);
            if (e >= 3 && (e - 3) < NV && evt(TBL[e-3])) h = 2;
            else if (h != 0) h--;
            chk(h == 0, (h == 0) ? "R9 idle/R8" : "R4 error low");
            cs_n    = (e + 1 < NV) ? TBL[e+1].cs : 2'b11;
            word_in = (e + 1 < NV) ? TBL[e+1].w : 22'h0;
            par_in  = (e < NV) ? pbit(TBL[e]) : 1'b0;
        end

        // R4 timing and R1 asynchronous clear
        cs_n = 2'b00; word_in = 22'h000003; par_in = 1'b0;   // even word
        @(negedge clk);
        cs_n = 2'b11; word_in = 22'h0; par_in = 1'b0;         // wrong parity
        @(negedge clk);
        chk(1'b1, "R4 not before n+3");
        @(negedge clk);
        chk(1'b1, "R4 not before n+3");
        @(negedge clk);
        chk(1'b0, "R4 low after n+3");
        #2 rst_n = 1'b0;
        #1 chk(1'b1, "R1 async clear");
        @(negedge clk);
        rst_n = 1'b1;

        // R2: error in flight when reset hits
        cs_n = 2'b01; word_in = 22'h000000; par_in = 1'b1;
        @(negedge clk);
        cs_n = 2'b11; par_in = 1'b0;                          // bad parity for it
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        // R8: parity 0 at first edge after release, word 0 selected
        cs_n = 2'b00; word_in = 22'h0; par_in = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        par_in = 1'b1;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk(1'b1, "R2/R8 no stale error");
        end
        done();
    end

endmodule